// File: doc/BRIEF.md
# Word Transfer Across Unrelated Clocks

This block moves one data word at a time from a source clock domain to a destination clock domain. The two clocks have no fixed phase or frequency relation. The source offers a word with a single-cycle valid. If the block is idle, it copies the word into a holding register and raises a request. The request crosses into the destination through a synchronizer. There, its rising edge produces one load strobe, and the strobe copies the held word into the output register.

The destination answers with a feedback flag. The flag rises with the load strobe and falls once the synchronized request has dropped. The flag crosses back to the source and clears the request. A `busy` output covers the whole four-phase round trip. A sender waits for `busy` to be low and then presents the next word. After the accepted cycle, the input bus may change freely.

The handshake does not depend on which clock is faster, so the block suits both fast-to-slow and slow-to-fast crossings. Its throughput is one word per full round trip.

Top module: `word_xfer_cdc`

## Requirements
- R1: After either reset is asserted, the outputs of that domain read zero. This means `busy`=0 for the source reset, and `out_valid`=0 and `out_data`=0 for the destination reset.
- R2: A word is accepted when `in_valid`=1 and `busy`=0 at a source clock edge. From that same edge onward, `busy` reads 1.
- R3: The accepted word is held in the source domain, so values driven on `in_data` after the accepted cycle do not change the word that is delivered.
- R4: `in_valid` while `busy`=1 is ignored. No extra word is delivered, and the held word is not overwritten.
- R5: Each accepted word produces exactly one `out_valid` pulse of one destination clock cycle. Words are delivered in acceptance order and none is lost or repeated.
- R6: While `out_valid`=1, `out_data` equals the accepted word, and it keeps that value until the next delivery.
- R7: `busy` stays high until the acknowledge has returned and been withdrawn. When `busy` falls, the word has already been delivered.
- R8: R2 to R7 hold both when the source clock is faster than the destination clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source domain clock |
| rst_src_n | input | 1 | Source domain asynchronous reset, active low |
| in_valid | input | 1 | Single-cycle offer of `in_data` |
| in_data | input | DATA_W | Word to transfer |
| busy | output | 1 | High while a transfer is in flight; offers are ignored |
| clk_dst | input | 1 | Destination domain clock |
| rst_dst_n | input | 1 | Destination domain asynchronous reset, active low |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a new word |
| out_data | output | DATA_W | Last delivered word |

## Verification
The bench pushes every 4-bit value through the block twice: once with a 100 MHz source and a 40 MHz destination, and once with the rates swapped. It scrambles `in_data` on the cycle after each accepted valid. A design that sampled the live bus would then deliver the scrambled value. Between transfers, the bench fires stray valids with junk words while `busy` is high. A block that accepted them would deliver extra or out-of-order words. The bench also starts the next word on the first cycle `busy` is low. This exposes an acknowledge taken straight from the strobe, which can drop `busy` before the destination has settled and so lose or duplicate a pulse at one of the two ratios.

// File: rtl/word_xfer_pkg.sv
// Package: shared defaults for the word transfer crossing.
// Assumes nothing; holds only constants used by every module.
package word_xfer_pkg;
    localparam int unsigned DEF_DATA_W      = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/wx_sync.sv
// Multi-flop level synchronizer.
// Assumes the input is a level held for several destination cycles;
// narrow pulses are not guaranteed to pass.
module wx_sync #(
    parameter int unsigned STAGES = word_xfer_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Purpose: first capture flop, may go metastable.
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Purpose: settling stage.
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wx_src.sv
// Source side: accepts a word when idle, freezes it, raises a sticky
// request and drops it once the synchronized acknowledge is seen.
// Assumes ack_async is a level from the destination domain.
module wx_src #(
    parameter int unsigned DATA_W      = word_xfer_pkg::DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = word_xfer_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ack_async,
    output logic              req_flag,
    output logic [DATA_W-1:0] hold_word,
    output logic              busy
);
    logic ack_s;
    logic accept;

    wx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ack_async),
        .q_sync (ack_s)
    );

    assign busy   = req_flag | ack_s;
    assign accept = in_valid & ~busy;

    // Purpose: sticky request, set on accept, cleared by returned ack.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      req_flag <= 1'b0;
        else if (accept) req_flag <= 1'b1;
        else if (ack_s)  req_flag <= 1'b0;
    end

    // Purpose: holding register, written only on an accepted offer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_word <= '0;
        else if (accept) hold_word <= in_data;
    end
endmodule

// File: rtl/wx_dst.sv
// Destination side: synchronizes the request, makes one load strobe on
// its rising edge, loads the word and keeps a feedback flag up until
// the request has been withdrawn. Assumes hold_word is frozen while
// the request is high.
module wx_dst #(
    parameter int unsigned DATA_W      = word_xfer_pkg::DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = word_xfer_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] hold_word,
    output logic              fb_flag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic req_s;
    logic req_d;
    logic load;

    wx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(req_async),
        .q_sync (req_s)
    );

    // Purpose: delayed copy of the synchronized request for edge detect.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req_s;
    end

    assign load = req_s & ~req_d;

    // Purpose: feedback flag, up from strobe until request drops.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fb_flag <= 1'b0;
        else if (load)  fb_flag <= 1'b1;
        else if (!req_s) fb_flag <= 1'b0;
    end

    // Purpose: output word and its one-cycle qualifier.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= load;
            if (load) out_data <= hold_word;
        end
    end
endmodule

// File: rtl/word_xfer_cdc.sv
// Top: four-phase handshake carrying one word between unrelated clocks.
// Assumes each reset is asynchronous in assertion; the sender waits for
// busy low before offering.
module word_xfer_cdc #(
    parameter int unsigned DATA_W      = word_xfer_pkg::DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = word_xfer_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk_src,
    input  logic              rst_src_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              busy,
    input  logic              clk_dst,
    input  logic              rst_dst_n,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic              req_flag;
    logic              fb_flag;
    logic [DATA_W-1:0] hold_word;

    wx_src #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk_src),
        .rst_n    (rst_src_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .ack_async(fb_flag),
        .req_flag (req_flag),
        .hold_word(hold_word),
        .busy     (busy)
    );

    wx_dst #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk      (clk_dst),
        .rst_n    (rst_dst_n),
        .req_async(req_flag),
        .hold_word(hold_word),
        .fb_flag  (fb_flag),
        .out_valid(out_valid),
        .out_data (out_data)
    );
endmodule

// File: rtl/word_xfer_cdc_chk.sv
// Checker for word_xfer_cdc, attached by bind below.
module word_xfer_cdc_chk #(
    parameter int unsigned DATA_W = word_xfer_pkg::DEF_DATA_W
) (
    input logic              clk_src,
    input logic              rst_src_n,
    input logic              clk_dst,
    input logic              rst_dst_n,
    input logic              in_valid,
    input logic              busy,
    input logic [DATA_W-1:0] hold_word,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    // R2: an accepted offer makes busy high from the next edge.
    p_busy_after_accept_r2: assert property (@(posedge clk_src) disable iff (!rst_src_n)
        (in_valid && !busy) |=> busy);

    // R3: the held word does not move while a transfer is in flight.
    p_hold_frozen_r3: assert property (@(posedge clk_src) disable iff (!rst_src_n)
        (busy && $past(busy)) |-> $stable(hold_word));

    // R4: busy only rises after an offer.
    p_busy_needs_valid_r4: assert property (@(posedge clk_src) disable iff (!rst_src_n)
        $rose(busy) |-> $past(in_valid));

    // R5: the delivery qualifier lasts a single destination cycle.
    p_single_strobe_r5: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
        out_valid |=> !out_valid);

    // R6: the delivered word is the held word.
    p_data_matches_r6: assert property (@(posedge clk_dst) disable iff (!rst_dst_n || !rst_src_n)
        out_valid |-> (out_data == hold_word));
endmodule

bind word_xfer_cdc word_xfer_cdc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_src  (clk_src),
    .rst_src_n(rst_src_n),
    .clk_dst  (clk_dst),
    .rst_dst_n(rst_dst_n),
    .in_valid (in_valid),
    .busy     (busy),
    .hold_word(hold_word),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/word_xfer_cdc_test.sv
`timescale 1ns/1ps
module word_xfer_cdc_test;
    localparam int W = 4;

    logic         clk_src = 1'b0;
    logic         clk_dst = 1'b0;
    logic         rst_src_n = 1'b0;
    logic         rst_dst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         busy;
    logic         out_valid;
    logic [W-1:0] out_data;

    int hs_src = 5;   // 100 MHz source in the first run
    int hs_dst = 12;  // ~40 MHz destination in the first run

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] exp_q [0:63];
    int tail = 0;
    int head = 0;
    logic prev_ov = 1'b0;

    word_xfer_cdc #(.DATA_W(W)) uut (
        .clk_src  (clk_src),
        .rst_src_n(rst_src_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .busy     (busy),
        .clk_dst  (clk_dst),
        .rst_dst_n(rst_dst_n),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    initial forever #(hs_src) clk_src = ~clk_src;
    initial forever #(hs_dst) clk_dst = ~clk_dst;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Destination monitor: order, single pulse, data hold (R5, R6).
    always @(negedge clk_dst) begin
        if (rst_dst_n) begin
            if (out_valid) begin
                check("R5 pulse width one cycle", int'(prev_ov), 0);
                check("R5 delivery before acceptance count", int'(head < tail), 1);
                check("R6 out_data at out_valid", int'(out_data), int'(exp_q[head]));
                head++;
            end else if (head > 0) begin
                check("R6 out_data held", int'(out_data), int'(exp_q[head-1]));
            end
            prev_ov = out_valid;
        end else begin
            prev_ov = 1'b0;
        end
    end

    task automatic run_phase(input int src_half, input int dst_half, input string tag);
        rst_src_n = 1'b0;
        rst_dst_n = 1'b0;
        in_valid  = 1'b0;
        hs_src = src_half;
        hs_dst = dst_half;
        #200;
        head = 0;
        tail = 0;
        // R1: reset state of both domains
        check({"R1 busy in reset ", tag}, int'(busy), 0);
        check({"R1 out_valid in reset ", tag}, int'(out_valid), 0);
        check({"R1 out_data in reset ", tag}, int'(out_data), 0);
        @(negedge clk_src);
        rst_src_n = 1'b1;
        rst_dst_n = 1'b1;
        for (int v = 0; v < 16; v++) begin
            int waited;
            logic [W-1:0] word;
            word = W'(v) ^ W'(src_half);
            waited = 0;
            while (busy && waited < 2000) begin
                @(negedge clk_src);
                waited++;
            end
            in_valid = 1'b1;
            in_data  = word;
            exp_q[tail] = word;
            tail++;
            @(negedge clk_src);
            // R2: busy high after accepting edge
            check({"R2 busy after accept ", tag}, int'(busy), 1);
            in_valid = 1'b0;
            in_data  = ~word;           // R3: scramble the bus
            if (v % 3 != 2) begin
                @(negedge clk_src);
                in_valid = 1'b1;        // R4: offer while busy
                in_data  = word ^ W'(5);
                @(negedge clk_src);
                in_valid = 1'b0;
                in_data  = W'(v + 7);
            end
            waited = 0;
            while (busy && waited < 2000) begin
                @(negedge clk_src);
                waited++;
            end
            check({"R7 busy released ", tag}, int'(busy), 0);
            // R7: word already delivered when busy drops
            check({"R7 delivered by busy fall ", tag}, head, tail);
        end
        repeat (20) @(negedge clk_dst);
        // R4 R5 R8: exactly the accepted words, no extras
        check({"R4 R5 R8 total deliveries ", tag}, head, 16);
        check({"R8 source idle at end ", tag}, int'(busy), 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        run_phase(5, 12, "fast-to-slow");   // R8
        run_phase(12, 5, "slow-to-fast");   // R8
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule